// File: doc/BRIEF.md
# Frame-Synchronous Dual-Converter Serial Receiver

This block is the interface master for a pair of daisy-chained 24-bit sigma-delta converters that share one serial data line. From its master clock it divides down a bit clock and drives an active-high frame pulse toward the converters. It then shifts in the returned serial stream and hands both samples to the rest of the chip as one parallel word, qualified by a single-cycle strobe. Each frame is 64 bit-clock slots long. With a 12.288 MHz master clock and the default divide-by-4, this gives a 48 kHz frame rate.

Frame timing comes entirely from the block's own sequencer, so capture begins at a fixed clock count after the frame edge, with no jitter. The data is left-justified. The most significant bit of the first converter arrives in the slot where the frame pulse is high. The 24 bits of the second converter follow directly after it. The last 16 slots of the frame are padding.

The sequencer is a three-state machine. IDLE is held during reset. The transition "start" moves it from IDLE to SHIFT on the first clock after reset is released. SHIFT covers the 48 data slots, and the transition "data_done" leaves SHIFT at the end of the last data slot for PAD. PAD covers the remaining slots, and the transition "wrap" returns it to SHIFT at the end of the final slot, which opens the next frame.

Top module: `adc_frame_rx`

## Requirements
- R1: The bit clock output has a period of CLK_DIV master clocks. It is high for the first CLK_DIV/2 clocks of every slot and low for the rest.
- R2: A frame is FRAME_SLOTS slots long. The frame pulse is active high and is high for exactly the first slot of each frame, so it repeats every FRAME_SLOTS*CLK_DIV clocks.
- R3: The frame pulse and the bit clock both rise on the same master clock edge.
- R4: Serial data is captured on the master clock edge where the bit clock falls, MSB first. The first captured bit is the one presented during the frame-pulse slot, with no delay slot.
- R5: The first WORD_W bits of a frame are placed in the upper WORD_W bits of `samples_o`. The next WORD_W bits are placed in the lower WORD_W bits.
- R6: `valid_o` is high for exactly one clock per frame. It rises exactly 47*CLK_DIV + CLK_DIV/2 clocks after the frame pulse rises. `samples_o` holds its value until the next strobe.
- R7: Serial data in slots after the 48th has no effect on `samples_o`.
- R8: While reset is high, the bit clock, the frame pulse and `valid_o` are low and `samples_o` is zero. On the first clock edge after reset is released, the frame pulse and the bit clock both rise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst | input | 1 | Synchronous reset, active high |
| sdata_i | input | 1 | Serial data from the converter chain |
| bclk_o | output | 1 | Bit clock to the converters |
| fsync_o | output | 1 | Active-high frame pulse to the converters |
| samples_o | output | 48 | First converter sample in the upper 24 bits, second converter sample in the lower 24 bits |
| valid_o | output | 1 | One-clock strobe when a new pair of samples is present |

## Verification
The bench builds the block with its defaults: divide-by-4, 64 slots and two 24-bit words. With these values the capture edge falls two clocks into each slot, which separates the capture edge from the slot boundary. The strobe latency of 190 clocks and the frame period of 256 clocks can then be measured exactly. A behavioural converter model drives the data line from the bit clock, so the bench can apply asymmetric patterns, opposite padding and a reset in mid-frame. These show bit order, word placement, that the padding slots are ignored, and the clean restart after reset.

// File: rtl/adc_frame_rx_pkg.sv
package adc_frame_rx_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_SHIFT = 2'd1,
        ST_PAD   = 2'd2
    } seq_state_t;
endpackage

// File: rtl/adc_frame_seq.sv
module adc_frame_seq
    import adc_frame_rx_pkg::*;
#(
    parameter int CLK_DIV     = 4,
    parameter int FRAME_SLOTS = 64,
    parameter int DATA_BITS   = 48
) (
    input  logic clk,
    input  logic rst,
    output logic bclk_o,
    output logic fsync_o,
    output logic sample_en,
    output logic last_en
);
    localparam int HALF  = CLK_DIV / 2;
    localparam int PH_W  = (CLK_DIV > 2) ? $clog2(CLK_DIV) : 1;
    localparam int SL_W  = $clog2(FRAME_SLOTS);

    seq_state_t       st_q, st_n;
    logic [PH_W-1:0]  ph_q, ph_n;
    logic [SL_W-1:0]  slot_q, slot_n;
    logic             slot_end;

    assign slot_end  = (ph_q == PH_W'(CLK_DIV - 1));
    assign sample_en = (st_q == ST_SHIFT) && (ph_q == PH_W'(HALF - 1));
    assign last_en   = sample_en && (slot_q == SL_W'(DATA_BITS - 1));

    always_comb begin
        st_n   = st_q;
        ph_n   = slot_end ? '0 : ph_q + 1'b1;
        slot_n = slot_q;
        unique case (st_q)
            ST_IDLE: begin
                st_n   = ST_SHIFT;
                ph_n   = '0;
                slot_n = '0;
            end
            ST_SHIFT: begin
                if (slot_end) begin
                    slot_n = slot_q + 1'b1;
                    if (slot_q == SL_W'(DATA_BITS - 1)) st_n = ST_PAD;
                end
            end
            ST_PAD: begin
                if (slot_end) begin
                    if (slot_q == SL_W'(FRAME_SLOTS - 1)) begin
                        slot_n = '0;
                        st_n   = ST_SHIFT;
                    end else begin
                        slot_n = slot_q + 1'b1;
                    end
                end
            end
            default: st_n = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q   <= ST_IDLE;
            ph_q   <= '0;
            slot_q <= '0;
        end else begin
            st_q   <= st_n;
            ph_q   <= ph_n;
            slot_q <= slot_n;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            bclk_o  <= 1'b0;
            fsync_o <= 1'b0;
        end else begin
            bclk_o  <= (st_n != ST_IDLE) && (ph_n < PH_W'(HALF));
            fsync_o <= (st_n == ST_SHIFT) && (slot_n == '0);
        end
    end

    a_r3_fsync_with_bclk: assert property (@(posedge clk) disable iff (rst)
        $rose(fsync_o) |-> $rose(bclk_o));
    a_r2_fsync_held: assert property (@(posedge clk) disable iff (rst)
        $rose(fsync_o) |=> fsync_o);
    a_r4_sample_on_fall: assert property (@(posedge clk) disable iff (rst)
        sample_en |=> $fell(bclk_o));
endmodule

// File: rtl/adc_frame_deser.sv
module adc_frame_deser #(
    parameter int DATA_BITS = 48
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 sdata_i,
    input  logic                 sample_en,
    input  logic                 last_en,
    output logic [DATA_BITS-1:0] samples_o,
    output logic                 valid_o
);
    logic [DATA_BITS-1:0] shift_q;
    logic [DATA_BITS-1:0] shift_n;

    assign shift_n = {shift_q[DATA_BITS-2:0], sdata_i};

    always_ff @(posedge clk) begin
        if (rst) begin
            shift_q   <= '0;
            samples_o <= '0;
            valid_o   <= 1'b0;
        end else begin
            valid_o <= last_en;
            if (sample_en) shift_q <= shift_n;
            if (last_en) samples_o <= shift_n;
        end
    end

    a_r6_valid_single: assert property (@(posedge clk) disable iff (rst)
        valid_o |=> !valid_o);
    a_r6_hold_between: assert property (@(posedge clk) disable iff (rst)
        !valid_o |-> $stable(samples_o) or $past(rst));
endmodule

// File: rtl/adc_frame_rx.sv
module adc_frame_rx #(
    parameter int CLK_DIV     = 4,
    parameter int FRAME_SLOTS = 64,
    parameter int WORD_W      = 24,
    parameter int N_WORDS     = 2
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      sdata_i,
    output logic                      bclk_o,
    output logic                      fsync_o,
    output logic [WORD_W*N_WORDS-1:0] samples_o,
    output logic                      valid_o
);
    localparam int DATA_BITS = WORD_W * N_WORDS;

    logic sample_en;
    logic last_en;

    adc_frame_seq #(
        .CLK_DIV    (CLK_DIV),
        .FRAME_SLOTS(FRAME_SLOTS),
        .DATA_BITS  (DATA_BITS)
    ) u_seq (
        .clk      (clk),
        .rst      (rst),
        .bclk_o   (bclk_o),
        .fsync_o  (fsync_o),
        .sample_en(sample_en),
        .last_en  (last_en)
    );

    adc_frame_deser #(
        .DATA_BITS(DATA_BITS)
    ) u_deser (
        .clk      (clk),
        .rst      (rst),
        .sdata_i  (sdata_i),
        .sample_en(sample_en),
        .last_en  (last_en),
        .samples_o(samples_o),
        .valid_o  (valid_o)
    );

    a_r8_reset_idle: assert property (@(posedge clk)
        rst |=> (!bclk_o && !fsync_o && !valid_o && samples_o == '0));
endmodule

// File: tb/adc_frame_rx_bench.sv
module adc_frame_rx_bench;
    localparam int DIV   = 4;
    localparam int HALF  = DIV / 2;
    localparam int SLOTS = 64;
    localparam int W     = 24;
    localparam int LIMIT = 100000;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic sdata = 1'b0;
    logic bclk, fsync, valid;
    logic [2*W-1:0] samples;

    int n_chk = 0;
    int n_err = 0;
    int wd = 0;
    bit mon_en = 1'b0;

    logic [W-1:0]  nxt_a = '0, nxt_b = '0;
    logic [15:0]   nxt_pad = '0;
    logic [63:0]   word = '0;
    int            idx = 0;

    always #2.5 clk = ~clk;

    adc_frame_rx #(.CLK_DIV(DIV), .FRAME_SLOTS(SLOTS), .WORD_W(W), .N_WORDS(2)) u_adc_frame_rx (
        .clk(clk), .rst(rst), .sdata_i(sdata), .bclk_o(bclk),
        .fsync_o(fsync), .samples_o(samples), .valid_o(valid)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // converter model: presents one bit per slot, changing just after the bit clock rises
    always @(posedge bclk) begin
        #1;
        if (fsync) begin
            word = {nxt_a, nxt_b, nxt_pad};
            idx = 0;
        end else begin
            idx++;
        end
        sdata = (idx < 64) ? word[63-idx] : 1'b0;
    end

    // timing monitor
    int cyc = 0, last_rise = 0, last_fs = 0, vcount = 0;
    bit have_rise = 0, have_fs = 0, bclk_p = 0, fs_p = 0, val_p = 0;
    always @(negedge clk) begin
        if (!mon_en) begin
            have_rise = 0; have_fs = 0; bclk_p = 0; fs_p = 0; val_p = 0; vcount = 0;
        end else begin
            cyc++;
            if (bclk && !bclk_p) begin
                if (have_rise) chk(cyc - last_rise == DIV, "R1", "bit clock period", cyc - last_rise, DIV);
                last_rise = cyc; have_rise = 1;
            end
            if (!bclk && bclk_p)
                chk(cyc - last_rise == HALF, "R1", "bit clock high time", cyc - last_rise, HALF);
            if (fsync && !fs_p) begin
                chk(bclk && !bclk_p, "R3", "bit clock rise with frame pulse", bclk, 1);
                if (have_fs) begin
                    chk(cyc - last_fs == SLOTS*DIV, "R2", "frame period", cyc - last_fs, SLOTS*DIV);
                    chk(vcount == 1, "R6", "strobes per frame", vcount, 1);
                end
                last_fs = cyc; have_fs = 1; vcount = 0;
            end
            if (!fsync && fs_p)
                chk(cyc - last_fs == DIV, "R2", "frame pulse width", cyc - last_fs, DIV);
            if (valid) begin
                vcount++;
                chk(!val_p, "R6", "strobe width", val_p, 0);
                chk(have_fs && (cyc - last_fs == 47*DIV + HALF), "R6", "strobe latency",
                    cyc - last_fs, 47*DIV + HALF);
            end
            bclk_p = bclk; fs_p = fsync; val_p = valid;
        end
    end

    always @(posedge clk) begin
        wd++;
        if (wd > LIMIT) begin
            n_chk++; n_err++;
            $display("FAIL watchdog: actual=%0d expected<%0d", wd, LIMIT);
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    task automatic wait_valid();
        @(negedge clk);
        while (!valid) @(negedge clk);
    endtask

    task automatic t_reset(input int hold);
        mon_en = 1'b0;
        rst = 1'b1;
        repeat (hold) begin
            @(negedge clk);
            chk(!bclk && !fsync && !valid, "R8", "outputs idle in reset", {bclk, fsync, valid}, 0);
            chk(samples == '0, "R8", "samples cleared in reset", samples, 0);
        end
        rst = 1'b0;
        mon_en = 1'b1;
        @(negedge clk);
        chk(fsync && bclk, "R8", "frame starts on first edge", {fsync, bclk}, 2'b11);
    endtask

    task automatic t_frame(input logic [W-1:0] a, input logic [W-1:0] b,
                           input logic [15:0] pad, input string req);
        wait_valid();
        nxt_a = a; nxt_b = b; nxt_pad = pad;
        wait_valid();
        chk(samples[2*W-1:W] == a, req, "first word", samples[2*W-1:W], a);
        chk(samples[W-1:0] == b, req, "second word", samples[W-1:0], b);
        repeat (100) @(negedge clk);
        chk(samples == {a, b}, "R6", "samples held", samples, {a, b});
    endtask

    task automatic t_mid_reset();
        repeat (77) @(negedge clk);
        t_reset(3);
    endtask

    initial begin
        t_reset(4);
        t_frame(24'hFFFFFF, 24'h000000, 16'h0000, "R5");
        t_frame(24'h800001, 24'h7FFFFE, 16'h0000, "R4");
        t_frame(24'h123456, 24'hABCDEF, 16'h0000, "R5");
        t_frame(24'hC3C3C3, 24'h3C3C3C, 16'hFFFF, "R7");
        t_frame(24'hC3C3C3, 24'h3C3C3C, 16'hA5A5, "R7");
        t_mid_reset();
        t_frame(24'hA5A5A5, 24'h5A5A5A, 16'h0F0F, "R4");
        t_frame(24'h000001, 24'h800000, 16'hFFFF, "R7");
        mon_en = 1'b0;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule